// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block maps CPU transaction addresses onto devices through a bank of programmable windows. Each window has an enable, a 4-bit target number, an 8-bit attribute, a power-of-two size and a size-aligned base in a 36-bit physical space. Every clock, the block compares the presented address against all enabled windows. One cycle later it reports a hit with the target, attribute and translated address of the winning window, or reports a miss.

A 32-bit word-addressed register port holds the window state. The port's map has two regions. In the lower region each window has four words. In the upper region each window has only two words. A few fixed offsets sit outside both regions: a barrier trigger, and a pair of remap words for one window in the upper region. Writing the barrier register emits a one-cycle pulse that carries a unit mask. Reads are combinational on the word index.

Top module: `cpu_addr_window_dec`

## Requirements
- R1: A window's control word holds the enable in bit 0, a barrier-enable flag in bit 1, the target ID in bits 7:4, the attribute in bits 15:8 and (size/64 KB − 1) in bits 31:16. A hit reports that window's target and attribute.
- R2: A window's base word carries physical address bits 31:16 in its bits 31:16 and address bits 35:32 in its bits 3:0. All 36 address bits take part in the match.
- R3: For a size-aligned power-of-two window, an address hits when base ≤ address < base + size and the enable is set. The first address past the end does not hit.
- R4: A window whose enable bit is clear never hits, whatever its other fields hold.
- R5: When several enabled windows match, the lowest-numbered one supplies the outputs.
- R6: When no window matches, miss is 1, hit is 0, and the target, attribute and translated address are all zero. Miss is also 1 during and right after reset.
- R7: Windows 0–7 sit at byte offset 16·n. Control is at +0, base at +4, remap-low at +8 and remap-high at +12 (word index = byte offset / 4). All four words read back what was written, limited to their implemented bits.
- R8: Windows 8–19 sit at byte offset 0x90 + 8·(n−8). Control is at +0 and base at +4. These windows have no other words.
- R9: Windows 0–7 and window 13 translate addresses, and window 13's remap words sit at 0xF0 (low) and 0xF4 (high). The translated address is {remap-high[3:0], remap-low[31:16] above the size mask, incoming bits inside the mask, incoming bits 15:0}. Every other window passes the address through unchanged.
- R10: Offsets 0x80–0x8F and 0xF8–0xFF read as zero. Writes to them change no stored state. The barrier register also reads as zero.
- R11: A write to byte offset 0x84 makes barrier_pulse 1 for exactly the next cycle, with barrier_mask equal to the written bits 15:0. At all other times both outputs are zero.
- R12: Lookup outputs are registered and appear one clock after the address is presented. A register write becomes visible to lookups from the clock after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 6 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_word, combinational |
| lookup_addr | input | 36 | CPU physical address to decode |
| hit | output | 1 | A window matched (registered) |
| miss | output | 1 | No window matched (registered) |
| tgt_id | output | 4 | Target ID of winning window |
| attr | output | 8 | Attribute of winning window |
| xlat_addr | output | 36 | Translated address |
| barrier_pulse | output | 1 | One-cycle barrier request |
| barrier_mask | output | 16 | Unit mask carried with the pulse |

## Verification
Lookup results and the barrier pulse are due exactly one clock after their stimulus. Read data is due in the same cycle as the word index. The bench drives inputs on falling edges. Its behavioural model updates at each rising edge from the state that held before that edge, and the outputs are compared at the next falling edge, so every comparison lands on the cycle in which the result is due. The directed lookups wait one full clock before they check. One case applies a lookup in the same cycle as the write that changes the window, and expects the old result first and the new result one cycle later.

// File: rtl/cpu_addr_window_dec.sv
module cpu_addr_window_dec #(
  parameter int NUM_WIN       = 20,
  parameter int NEAR_WIN      = 8,
  parameter int FAR_REMAP_WIN = 13,
  parameter int AW            = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [5:0]    reg_word,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [AW-1:0] lookup_addr,
  output logic          hit,
  output logic          miss,
  output logic [3:0]    tgt_id,
  output logic [7:0]    attr,
  output logic [AW-1:0] xlat_addr,
  output logic          barrier_pulse,
  output logic [15:0]   barrier_mask
);
  localparam int HW = AW - 32;
  localparam int WW = $clog2(NUM_WIN);
  localparam logic [7:0] NEAR_END    = 8'(NEAR_WIN * 16);
  localparam logic [7:0] BARRIER_OFF = 8'h84;
  localparam logic [7:0] FAR_BASE    = 8'h90;
  localparam logic [7:0] FAR_END     = 8'(144 + (NUM_WIN - NEAR_WIN) * 8);
  localparam logic [7:0] XRMP_LO     = 8'hF0;
  localparam logic [7:0] XRMP_HI     = 8'hF4;

  function automatic logic can_remap(input logic [WW-1:0] w);
    return (int'(w) < NEAR_WIN) || (int'(w) == FAR_REMAP_WIN);
  endfunction

  logic [31:0]   ctrl_q [NUM_WIN];
  logic [15:0]   blo_q  [NUM_WIN];
  logic [HW-1:0] bhi_q  [NUM_WIN];
  logic [15:0]   rlo_q  [NUM_WIN];
  logic [HW-1:0] rhi_q  [NUM_WIN];

  logic [7:0]    wa, far_rel;
  logic          dec_ok, dec_bar;
  logic [WW-1:0] dec_win;
  logic [1:0]    dec_kind;

  assign wa      = {reg_word, 2'b00};
  assign far_rel = wa - FAR_BASE;

  always_comb begin
    dec_ok   = 1'b0;
    dec_bar  = 1'b0;
    dec_win  = '0;
    dec_kind = 2'd0;
    if (wa < NEAR_END) begin
      dec_ok   = 1'b1;
      dec_win  = WW'(wa >> 4);
      dec_kind = wa[3:2];
    end else if (wa == BARRIER_OFF) begin
      dec_bar = 1'b1;
    end else if (wa >= FAR_BASE && wa < FAR_END) begin
      dec_ok   = 1'b1;
      dec_win  = WW'(NEAR_WIN) + WW'(far_rel >> 3);
      dec_kind = {1'b0, wa[2]};
    end else if (wa == XRMP_LO || wa == XRMP_HI) begin
      dec_ok   = 1'b1;
      dec_win  = WW'(FAR_REMAP_WIN);
      dec_kind = {1'b1, wa[2]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        ctrl_q[i] <= '0;
        blo_q[i]  <= '0;
        bhi_q[i]  <= '0;
        rlo_q[i]  <= '0;
        rhi_q[i]  <= '0;
      end
    end else if (reg_wr && dec_ok) begin
      case (dec_kind)
        2'd0: ctrl_q[dec_win] <= reg_wdata;
        2'd1: begin
          blo_q[dec_win] <= reg_wdata[31:16];
          bhi_q[dec_win] <= reg_wdata[HW-1:0];
        end
        2'd2: if (can_remap(dec_win)) rlo_q[dec_win] <= reg_wdata[31:16];
        default: if (can_remap(dec_win)) rhi_q[dec_win] <= reg_wdata[HW-1:0];
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (dec_ok) begin
      case (dec_kind)
        2'd0: reg_rdata = ctrl_q[dec_win];
        2'd1: reg_rdata = {blo_q[dec_win], 12'b0, bhi_q[dec_win]};
        2'd2: if (can_remap(dec_win)) reg_rdata = {rlo_q[dec_win], 16'b0};
        default: if (can_remap(dec_win)) reg_rdata = {28'b0, rhi_q[dec_win]};
      endcase
    end
  end

  logic [NUM_WIN-1:0] win_hit;
  logic [AW-1:0]      win_xlat [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [15:0] msk;
    assign msk = ctrl_q[g][31:16];
    assign win_hit[g] = ctrl_q[g][0] && (lookup_addr[AW-1:32] == bhi_q[g]) &&
                        (((lookup_addr[31:16] ^ blo_q[g]) & ~msk) == 16'h0);
    if (g < NEAR_WIN || g == FAR_REMAP_WIN) begin : g_rmp
      assign win_xlat[g] = {rhi_q[g], (rlo_q[g] & ~msk) | (lookup_addr[31:16] & msk),
                            lookup_addr[15:0]};
    end else begin : g_pass
      assign win_xlat[g] = lookup_addr;
    end
  end

  logic          found;
  logic [WW-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (win_hit[w]) begin
        found = 1'b1;
        sel   = WW'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit           <= 1'b0;
      miss          <= 1'b1;
      tgt_id        <= '0;
      attr          <= '0;
      xlat_addr     <= '0;
      barrier_pulse <= 1'b0;
      barrier_mask  <= '0;
    end else begin
      hit           <= found;
      miss          <= !found;
      tgt_id        <= found ? ctrl_q[sel][7:4]  : 4'h0;
      attr          <= found ? ctrl_q[sel][15:8] : 8'h0;
      xlat_addr     <= found ? win_xlat[sel]     : '0;
      barrier_pulse <= reg_wr && dec_bar;
      barrier_mask  <= (reg_wr && dec_bar) ? reg_wdata[15:0] : 16'h0;
    end
  end
endmodule

// File: rtl/cpu_addr_window_dec_chk.sv
module cpu_addr_window_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [5:0]  reg_word,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic [35:0] lookup_addr,
  input logic        hit,
  input logic        miss,
  input logic [3:0]  tgt_id,
  input logic [7:0]  attr,
  input logic [35:0] xlat_addr,
  input logic        barrier_pulse,
  input logic [15:0] barrier_mask
);
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n) hit ^ miss); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (tgt_id == 4'h0 && attr == 8'h0 && xlat_addr == 36'h0)); // R6
  AST_BARRIER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_word == 6'h21) |=> (barrier_pulse && barrier_mask == $past(reg_wdata[15:0]))); // R11
  AST_BARRIER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_word == 6'h21) |=> (!barrier_pulse && barrier_mask == 16'h0)); // R11
  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word >= 6'h20 && reg_word <= 6'h23) |-> reg_rdata == 32'h0); // R10
  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> xlat_addr[15:0] == $past(lookup_addr[15:0])); // R9
endmodule

bind cpu_addr_window_dec cpu_addr_window_dec_chk u_chk (.*);

// File: tb/test_cpu_addr_window_dec.sv
module test_cpu_addr_window_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  word = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [35:0] lk = '0;
  logic        hit, miss, pulse;
  logic [3:0]  tgt;
  logic [7:0]  at;
  logic [35:0] xl;
  logic [15:0] mask;

  always #10 clk = ~clk;

  cpu_addr_window_dec i_cpu_addr_window_dec (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_word(word), .reg_wdata(wdata),
    .reg_rdata(rdata), .lookup_addr(lk), .hit(hit), .miss(miss), .tgt_id(tgt),
    .attr(at), .xlat_addr(xl), .barrier_pulse(pulse), .barrier_mask(mask));

  int checks = 0;
  int fails  = 0;
  bit live   = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [31:0] m_ctrl [20];
  logic [31:0] m_base [20];
  logic [31:0] m_rlo  [20];
  logic [31:0] m_rhi  [20];
  logic        e_hit, e_miss, e_pulse;
  logic [3:0]  e_tgt;
  logic [7:0]  e_at;
  logic [35:0] e_xl;
  logic [15:0] e_mask;

  function automatic bit remappable(int w);
    return w < 8 || w == 13;
  endfunction

  task automatic model_write(int off, logic [31:0] d);
    int w, k;
    if (off < 128) begin
      w = off / 16; k = (off % 16) / 4;
    end else if (off >= 144 && off < 240) begin
      w = 8 + (off - 144) / 8; k = ((off - 144) % 8) / 4;
    end else if (off == 240) begin
      w = 13; k = 2;
    end else if (off == 244) begin
      w = 13; k = 3;
    end else return;
    case (k)
      0: m_ctrl[w] = d;
      1: m_base[w] = d & 32'hFFFF_000F;
      2: m_rlo[w]  = d & 32'hFFFF_0000;
      default: m_rhi[w] = d & 32'h0000_000F;
    endcase
  endtask

  task automatic model_look(logic [35:0] a);
    logic [63:0] wb, sz, a64, rb;
    a64 = {28'b0, a};
    e_hit = 1'b0; e_miss = 1'b1; e_tgt = '0; e_at = '0; e_xl = '0;
    for (int w = 0; w < 20; w++) begin
      wb = {28'b0, m_base[w][3:0], m_base[w][31:16], 16'h0};
      sz = ({48'b0, m_ctrl[w][31:16]} + 64'd1) << 16;
      if (m_ctrl[w][0] && a64 >= wb && a64 < wb + sz) begin
        e_hit = 1'b1; e_miss = 1'b0;
        e_tgt = m_ctrl[w][7:4]; e_at = m_ctrl[w][15:8];
        if (remappable(w)) begin
          rb = {28'b0, m_rhi[w][3:0], m_rlo[w][31:16], 16'h0};
          e_xl = 36'(rb + (a64 - wb));
        end else e_xl = a;
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 20; i++) begin
        m_ctrl[i] = '0; m_base[i] = '0; m_rlo[i] = '0; m_rhi[i] = '0;
      end
      e_hit = 1'b0; e_miss = 1'b1; e_tgt = '0; e_at = '0; e_xl = '0;
      e_pulse = 1'b0; e_mask = '0;
    end else begin
      model_look(lk);
      e_pulse = wr && word == 6'h21;
      e_mask  = e_pulse ? wdata[15:0] : 16'h0;
      if (wr) model_write(int'(word) * 4, wdata);
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk("R12 per-cycle lookup", {hit, miss, tgt, at, xl}, {e_hit, e_miss, e_tgt, e_at, e_xl});
      chk("R11 per-cycle barrier", {pulse, mask}, {e_pulse, e_mask});
    end
  end

  task automatic reg_write(logic [5:0] w, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; word = w; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(string req, logic [5:0] w, logic [31:0] exp);
    @(negedge clk);
    word = w;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic look(string req, logic [35:0] a, logic eh, logic [3:0] et,
                      logic [7:0] ea, logic [35:0] ex);
    @(negedge clk);
    lk = a;
    @(negedge clk);
    chk(req, {hit, miss, tgt, at, xl}, {eh, !eh, et, ea, ex});
  endtask

  logic [35:0] bases [5] = '{36'h1_2000_0000, 36'h0_8000_0000, 36'h0_9000_0000,
                              36'h0_90FF_0000, 36'h0_0000_0000};

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset state", {hit, miss, tgt, at, xl, pulse, mask}, {1'b0, 1'b1, 4'h0, 8'h0, 36'h0, 1'b0, 16'h0});
    rst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;
    reg_read("R7 reset readback", 6'h08, 32'h0);

    reg_write(6'h08, 32'h000F_A351);
    reg_write(6'h09, 32'h2000_0001);
    reg_write(6'h0A, 32'h2000_0000);
    reg_write(6'h0B, 32'h0000_0001);
    reg_write(6'h2E, 32'h0000_1E91);
    reg_write(6'h2F, 32'h8000_0000);
    reg_write(6'h3C, 32'h4567_0000);
    reg_write(6'h3D, 32'h0000_0002);
    reg_write(6'h28, 32'h00FF_4431);
    reg_write(6'h29, 32'h9000_0000);
    reg_write(6'h14, 32'h0000_6671);
    reg_write(6'h15, 32'h9000_0000);
    reg_write(6'h16, 32'h9000_0000);

    look("R1 window fields", 36'h1_2003_4567, 1'b1, 4'h5, 8'hA3, 36'h1_2003_4567);
    look("R2 upper address bits differ", 36'h0_2003_4567, 1'b0, 4'h0, 8'h0, 36'h0);
    look("R3 first address past end", 36'h1_2010_0000, 1'b0, 4'h0, 8'h0, 36'h0);
    look("R3 last address below base", 36'h1_1FFF_FFFF, 1'b0, 4'h0, 8'h0, 36'h0);
    look("R9 far window remap", 36'h0_8000_ABCD, 1'b1, 4'h9, 8'h1E, 36'h2_4567_ABCD);
    look("R9 far window pass-through", 36'h0_90AB_CDEF, 1'b1, 4'h3, 8'h44, 36'h0_90AB_CDEF);
    look("R5 lowest window wins", 36'h0_9000_1234, 1'b1, 4'h7, 8'h66, 36'h0_9000_1234);
    look("R3 end of small window", 36'h0_9001_0000, 1'b1, 4'h3, 8'h44, 36'h0_9001_0000);
    look("R6 miss outputs zero", 36'hF_0000_0000, 1'b0, 4'h0, 8'h0, 36'h0);

    reg_read("R7 near ctrl readback", 6'h08, 32'h000F_A351);
    reg_read("R7 near base readback", 6'h09, 32'h2000_0001);
    reg_read("R7 near remap-high readback", 6'h0B, 32'h0000_0001);
    reg_read("R8 far base readback", 6'h29, 32'h9000_0000);
    reg_read("R8 far ctrl readback", 6'h2E, 32'h0000_1E91);
    reg_read("R9 isolated remap readback", 6'h3C, 32'h4567_0000);

    reg_write(6'h22, 32'hDEAD_BEEF);
    reg_write(6'h3E, 32'hDEAD_BEEF);
    reg_write(6'h3F, 32'hFFFF_FFFF);
    reg_read("R10 hole reads zero", 6'h22, 32'h0);
    reg_read("R10 tail reads zero", 6'h3E, 32'h0);
    reg_read("R10 barrier reads zero", 6'h21, 32'h0);
    reg_read("R10 remap unchanged", 6'h3C, 32'h4567_0000);
    look("R10 lookup unchanged", 36'h0_8000_ABCD, 1'b1, 4'h9, 8'h1E, 36'h2_4567_ABCD);

    reg_write(6'h21, 32'h0000_FFFF);
    chk("R11 pulse with mask", {pulse, mask}, {1'b1, 16'hFFFF});
    @(negedge clk);
    chk("R11 pulse lasts one cycle", {pulse, mask}, {1'b0, 16'h0});

    reg_write(6'h14, 32'h0000_6670);
    look("R4 enable clear", 36'h0_9000_1234, 1'b1, 4'h3, 8'h44, 36'h0_9000_1234);
    reg_write(6'h2E, 32'h0);
    reg_write(6'h2F, 32'h0);
    look("R4 zeroed window misses", 36'h0_8000_ABCD, 1'b0, 4'h0, 8'h0, 36'h0);

    @(negedge clk);
    lk = 36'h0_9000_1234;
    wr = 1'b1; word = 6'h14; wdata = 32'h0000_6671;
    @(negedge clk);
    wr = 1'b0;
    chk("R12 lookup at write edge sees old state", {hit, tgt}, {1'b1, 4'h3});
    @(negedge clk);
    chk("R12 lookup after write sees new state", {hit, tgt}, {1'b1, 4'h7});

    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      lk = bases[$urandom % 5] + 36'($urandom % 32'h0020_0000);
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule